// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static RAM that shares one data bus for reading and writing. The host raises a request with an address, a direction flag and, for a write, a data word. The block then walks the memory's active-low chip-select, output-enable and write-enable strobes through a fixed order of phases. Each phase lasts a whole number of clock cycles, set by parameters, so that the memory's setup, pulse-width, hold, access and bus-release times are all met. When the access is over, the host gets a one-cycle acknowledge, together with the returned word for a read.

The state machine has six states. `ST_IDLE` waits for a request. A write goes through `ST_WSETUP`, where the address and data are driven with the strobes high, then `ST_WPULSE`, where chip-select and write-enable are low, then `ST_WHOLD`, where the strobes are high again and the address and data are still held. It then returns to `ST_IDLE`. A read goes through `ST_RACCESS`, where chip-select and output-enable are low, then `ST_RFLOAT`, where the strobes are released and the block waits for the memory to float the bus. It then returns to `ST_IDLE`. The transitions are:
- IDLE→WSETUP or IDLE→RACCESS on an accepted request.
- WSETUP→WPULSE, WPULSE→WHOLD, WHOLD→IDLE, RACCESS→RFLOAT and RFLOAT→IDLE, each when its phase counter expires.

The block drives the data bus only in the three write states. The returned word is sampled on the last cycle of `ST_RACCESS`.

Top module: `asram_seq`

## Requirements
- R1: During reset and in the first idle cycle after it, `sram_cs_n_o`, `sram_oe_n_o` and `sram_we_n_o` are 1, `sram_dq_oe_o` and `ack_o` are 0.
- R2: An accepted write first spends T_AS cycles driving the latched address and data (`sram_dq_oe_o`=1) with all three strobes high. Chip-select and write-enable then fall in the same cycle.
- R3: Chip-select and write-enable stay low together for exactly max(T_WP, T_DS, T_CSW) cycles, with output-enable high.
- R4: After write-enable rises, the address, the data and the bus drive stay unchanged for max(T_AH, T_DH) cycles with all strobes high. The bus is then released.
- R5: A write's acknowledge is a single-cycle pulse in the cycle right after the last hold cycle.
- R6: An accepted read holds chip-select and output-enable low for exactly max(T_AA, T_ACS, T_OE) cycles. Write-enable stays high throughout and the bus is never driven. The word on `sram_dq_i` in the last of those cycles is captured.
- R7: A read's acknowledge is a single-cycle pulse in the cycle after the access phase. `rdata_o` carries the captured word and keeps it until the next read captures.
- R8: After a read, the block waits T_OZ cycles with all strobes high and the bus undriven before it can accept a request. The address is held throughout.
- R9: A request is accepted only in `ST_IDLE` and only in a cycle where `ack_o` is 0. Changes to the request inputs at other times have no effect. A request held high through an acknowledge starts the next access at the first cycle where both conditions are met.
- R10: `sram_addr_o` and `sram_dq_o` change only at the clock edge that accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write word |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Word returned by the last read |
| sram_addr_o | output | ADDR_W | Memory address lines |
| sram_cs_n_o | output | 1 | Chip select, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_dq_o | output | DATA_W | Value driven onto the shared bus |
| sram_dq_oe_o | output | 1 | 1 while the block drives the shared bus |
| sram_dq_i | input | DATA_W | Value seen on the shared bus |

## Verification
The assertions assume three things:
- The host holds `req_i` and its fields steady from when it raises a request until it sees `ack_o`.
- The memory's real delays fit inside the cycle counts set by the parameters.
- Every timing parameter is at least 1.

The bench holds the request fields fixed until the acknowledge. The one exception is the deliberate busy-time change for R9, which the block must ignore. The bench's memory model returns a garbage word until output-enable has been low for the full access count. It keeps claiming the bus for T_OZ cycles after release, so any early capture or early drive shows up at the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RFLOAT
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    a_r3_timer_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (sample) begin
            word_q <= bus_in;
        end
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int T_AS   = 1,
    parameter int T_WP   = 2,
    parameter int T_DS   = 1,
    parameter int T_CSW  = 2,
    parameter int T_AH   = 1,
    parameter int T_DH   = 1,
    parameter int T_AA   = 2,
    parameter int T_ACS  = 2,
    parameter int T_OE   = 1,
    parameter int T_OZ   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_cs_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int PULSE_LEN = max3(T_WP, T_DS, T_CSW);
    localparam int HOLD_LEN  = max2(T_AH, T_DH);
    localparam int READ_LEN  = max3(T_AA, T_ACS, T_OE);
    localparam int LONGEST   = max3(max2(T_AS, T_OZ), max2(PULSE_LEN, HOLD_LEN), READ_LEN);
    localparam int CNT_W     = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_AS - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_LEN - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_LEN - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ_LEN - 1);
    localparam logic [CNT_W-1:0] LD_FLOAT = CNT_W'(T_OZ - 1);

    seq_state_e       state_q, state_d;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             rd_sample;
    logic             ack_q, ack_d;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr_in (req_addr_i),
        .data_in (req_wdata_i),
        .addr_q  (sram_addr_o),
        .data_q  (sram_dq_o)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rd_sample),
        .bus_in (sram_dq_i),
        .word_q (rdata_o)
    );

    // Next-state and phase-timer control
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_sample = 1'b0;
        ack_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i && !ack_q) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_wr_i) begin
                        state_d = ST_WSETUP;
                        tmr_val = LD_SETUP;
                    end else begin
                        state_d = ST_RACCESS;
                        tmr_val = LD_READ;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_done) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b1;
                end
            end
            ST_RACCESS: begin
                if (tmr_done) begin
                    state_d   = ST_RFLOAT;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_FLOAT;
                    rd_sample = 1'b1;
                    ack_d     = 1'b1;
                end
            end
            ST_RFLOAT: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
        end
    end

    assign ack_o = ack_q;

    // Strobe and bus-drive decode
    always_comb begin
        sram_cs_n_o  = 1'b1;
        sram_oe_n_o  = 1'b1;
        sram_we_n_o  = 1'b1;
        sram_dq_oe_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WSETUP: sram_dq_oe_o = 1'b1;
            ST_WPULSE: begin
                sram_dq_oe_o = 1'b1;
                sram_cs_n_o  = 1'b0;
                sram_we_n_o  = 1'b0;
            end
            ST_WHOLD:  sram_dq_oe_o = 1'b1;
            ST_RACCESS: begin
                sram_cs_n_o = 1'b0;
                sram_oe_n_o = 1'b0;
            end
            ST_RFLOAT: ;
            default:   ;
        endcase
    end

    // R6: write strobe never active while the memory is told to drive
    a_r6_we_high_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n_o |-> sram_we_n_o);

    // R8: no contention: bus never driven while output-enable is low
    a_r8_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe_o |-> sram_oe_n_o);

    // R8: at least one released cycle before any drive after a read
    a_r8_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n_o) |=> !sram_dq_oe_o);

    // R3: chip-select and write-enable fall together
    a_r3_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n_o) |-> $fell(sram_cs_n_o));

    // R2: data already on the bus before the write pulse begins
    a_r2_data_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n_o) |-> $past(sram_dq_oe_o));

    // R4: address and data unchanged as write-enable rises
    a_r4_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n_o) |-> (sram_dq_oe_o && $stable(sram_addr_o) && $stable(sram_dq_o)));

    // R5, R7: acknowledge lasts one cycle
    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R10: memory address only moves when a request is taken
    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(sram_addr_o));

    // R9: nothing is taken outside idle
    a_r9_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (state_q == ST_IDLE && !ack_o));
endmodule

// File: tb/asram_seq_tb.sv
module asram_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    localparam int P_AS = 2, P_WP = 3, P_DS = 2, P_CSW = 2, P_AH = 1, P_DH = 2;
    localparam int P_AA = 3, P_ACS = 2, P_OE = 1, P_OZ = 2;

    // Expected phase lengths, worked out from the requirements
    localparam int E_SETUP = P_AS;
    localparam int E_PULSE = 3;
    localparam int E_HOLD  = 2;
    localparam int E_READ  = 3;
    localparam int W_TOT   = E_SETUP + E_PULSE + E_HOLD;
    localparam int R_TOT   = E_READ + P_OZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ack;
    logic [DW-1:0] rdata;
    logic [AW-1:0] s_addr;
    logic s_cs_n, s_oe_n, s_we_n, s_dq_oe;
    logic [DW-1:0] s_dq_o, s_dq_i;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit timeout = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_seq #(
        .ADDR_W(AW), .DATA_W(DW), .T_AS(P_AS), .T_WP(P_WP), .T_DS(P_DS), .T_CSW(P_CSW),
        .T_AH(P_AH), .T_DH(P_DH), .T_AA(P_AA), .T_ACS(P_ACS), .T_OE(P_OE), .T_OZ(P_OZ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .ack_o(ack), .rdata_o(rdata), .sram_addr_o(s_addr),
        .sram_cs_n_o(s_cs_n), .sram_oe_n_o(s_oe_n), .sram_we_n_o(s_we_n),
        .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe), .sram_dq_i(s_dq_i)
    );

    // Behavioural asynchronous memory
    logic [DW-1:0] sram_mem [0:255];
    int low_cnt = 0, float_cnt = 0;
    initial for (int i = 0; i < 256; i++) sram_mem[i] = '0;
    always @(posedge clk) begin
        if (!s_cs_n && !s_oe_n) begin
            low_cnt   <= low_cnt + 1;
            float_cnt <= P_OZ;
        end else begin
            low_cnt <= 0;
            if (float_cnt > 0) float_cnt <= float_cnt - 1;
        end
        if (!s_cs_n && !s_we_n) sram_mem[s_addr] <= s_dq_o;
    end
    assign s_dq_i = (!s_cs_n && !s_oe_n && low_cnt >= E_READ - 1) ? sram_mem[s_addr] : 16'hBAD0;
    wire mem_drives = (!s_cs_n && !s_oe_n) || (float_cnt != 0);

    // Reference model
    logic [DW-1:0] exp_mem [0:255];
    initial for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    bit m_busy = 0, m_wr = 0, m_ack = 0, old_ack;
    int m_t = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ack = 0; m_t = 0; m_addr = '0; m_data = '0; m_rdata = '0;
        end else begin
            old_ack = m_ack;
            m_ack = 0;
            if (!m_busy) begin
                if (req && !old_ack) begin
                    m_busy = 1; m_t = 1; m_wr = req_wr; m_addr = req_addr; m_data = req_wdata;
                    if (req_wr) exp_mem[req_addr] = req_wdata;
                end
            end else if (m_wr && m_t == W_TOT) begin
                m_busy = 0; m_ack = 1;
            end else if (!m_wr && m_t == R_TOT) begin
                m_busy = 0;
            end else begin
                m_t++;
                if (!m_wr && m_t == E_READ + 1) begin
                    m_ack = 1; m_rdata = exp_mem[m_addr];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (t=%0d)", tag, what, act, exp, m_t);
        end
    endtask

    function automatic string phase_tag();
        if (!m_busy) return "R9";
        if (m_wr) begin
            if (m_t <= E_SETUP) return "R2";
            if (m_t <= E_SETUP + E_PULSE) return "R3";
            return "R4";
        end
        if (m_t <= E_READ) return "R6";
        return "R8";
    endfunction

    bit running = 0;
    always @(negedge clk) begin
        if (rst_n && running) begin
            bit pulse, rd_act;
            logic [3:0] exp_str, act_str;
            pulse  = m_busy && m_wr && m_t > E_SETUP && m_t <= E_SETUP + E_PULSE;
            rd_act = m_busy && !m_wr && m_t <= E_READ;
            exp_str = {!(pulse || rd_act), !rd_act, !pulse, m_busy && m_wr};
            act_str = {s_cs_n, s_oe_n, s_we_n, s_dq_oe};
            chk(phase_tag(), 32'(act_str), 32'(exp_str), "cs/oe/we/drive");
            chk(m_wr ? "R5" : "R7", 32'(ack), 32'(m_ack), "ack");
            chk("R7", 32'(rdata), 32'(m_rdata), "rdata");
            chk("R10", 32'(s_addr), 32'(m_addr), "address");
            if (s_dq_oe) chk("R10", 32'(s_dq_o), 32'(m_data), "bus data");
            chk("R8", 32'(s_dq_oe && mem_drives), 32'd0, "bus contention");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !timeout) timeout = 1'b1;
    end

    logic [DW-1:0] last_rd;

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!ack && !timeout);
        last_rd = rdata;
        req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle strobes during reset
        chk("R1", 32'({s_cs_n, s_oe_n, s_we_n, s_dq_oe, ack}), 32'b11100, "reset outputs");
        rst_n = 1;
        @(negedge clk);
        chk("R1", 32'({s_cs_n, s_oe_n, s_we_n, s_dq_oe, ack}), 32'b11100, "post-reset outputs");
        running = 1;

        access(1, 8'h12, 16'hA5A5);
        access(0, 8'h12, '0);
        chk("R7", 32'(last_rd), 32'hA5A5, "read after write");
        access(1, 8'h34, 16'h1234);
        access(1, 8'hFF, 16'hFFFF);
        access(0, 8'h34, '0);
        chk("R6", 32'(last_rd), 32'h1234, "read word 0x34");
        access(0, 8'hFF, '0);
        chk("R6", 32'(last_rd), 32'hFFFF, "read word 0xFF");
        access(0, 8'h05, '0);
        chk("R7", 32'(last_rd), 32'h0000, "unwritten word");

        // R9: request held high through acknowledges
        @(negedge clk);
        req = 1; req_wr = 1; req_addr = 8'h40; req_wdata = 16'h5A5A;
        do @(negedge clk); while (!ack && !timeout);
        req_wr = 0;
        do @(negedge clk); while (!ack && !timeout);
        chk("R9", 32'(rdata), 32'h5A5A, "held-request write then read");
        req = 0;

        // R9: request fields changed while busy are ignored
        @(negedge clk);
        req = 1; req_wr = 0; req_addr = 8'h34;
        repeat (2) @(negedge clk);
        req_wr = 1; req_addr = 8'h12; req_wdata = 16'h7777;
        do @(negedge clk); while (!ack && !timeout);
        req = 0;
        chk("R9", 32'(rdata), 32'h1234, "read kept first address");
        access(0, 8'h12, '0);
        chk("R9", 32'(last_rd), 32'hA5A5, "busy-time write not performed");

        repeat (6) @(negedge clk);
        running = 0;
        if (timeout) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule